// File: doc/BRIEF.md
# Firmware Command Forwarding Port with Status

This block lets firmware push multi-word commands, one word at a time, through a single request register. Each accepted word is passed to a downstream command consumer over a valid/ready handshake. The first word of a command is a header, and its length field says how many data words follow. After the last word of a command, the consumer answers with a one-cycle acknowledgment and a status bit.

A read-only status word tracks the exchange and has four flags:
- next-word readiness;
- new-command readiness;
- acknowledgment received;
- the error code returned with the acknowledgment.

A one-cycle done pulse follows every acknowledgment and is meant to feed an interrupt. Firmware polls the two readiness flags before it writes, and it checks the error code once the acknowledged flag is set. Deasserting the enable input clears the port.

Top module: `swcmd_status_port`

## Requirements
- R1: The status word has word-ready at bit 0, command-ready at bit 1, error code at bit 2 and acknowledged at bit 3. Bits 31:4 always read zero, and the whole word is zero during reset.
- R2: An accepted write (write strobe with bit 0 high) drops bit 0 on the next cycle. Bit 0 stays low until the consumer has taken that word.
- R3: A forwarded word keeps `cmd_valid` high and `cmd_data` unchanged until `cmd_ready` is seen high at a clock edge.
- R4: The header carries the extra-word count in bits [7:4], and a command is the header plus that many words. A count above 12 is treated as 12.
- R5: Bit 1 is high only between commands. It is low while a command is partly written and while its acknowledgment is still awaited.
- R6: Once the final word of a command has been taken downstream, bit 0 stays low until `ack_i` arrives.
- R7: Bit 3 is cleared by every accepted write. It is set in the cycle after an awaited `ack_i`.
- R8: Bit 2 captures `ack_err_i` with each awaited acknowledgment: 0 means success and 1 means error.
- R9: `done_o` is high for exactly one cycle, the cycle after an awaited acknowledgment.
- R10: A write while bit 0 is low is ignored. No word is forwarded and the flags are unchanged.
- R11: While `enable` is low, bits 1:0 read 0. A low `enable` also clears the word count, bit 3, bit 2 and any pending word, so that re-enabling starts from a fresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enable; low clears state |
| wr_en | input | 1 | Request register write strobe |
| wr_data | input | 32 | Command word written by firmware |
| status | output | 32 | Read-only status word |
| cmd_valid | output | 1 | Word valid toward consumer |
| cmd_data | output | 32 | Word toward consumer |
| cmd_ready | input | 1 | Consumer accepts word |
| ack_i | input | 1 | One-cycle command acknowledgment |
| ack_err_i | input | 1 | Status bit sampled with `ack_i` |
| done_o | output | 1 | One-cycle command-done pulse |

## Verification
The assertions check the following on every cycle:
- the handshake hold;
- zero upper status bits;
- that both ready flags are low while disabled;
- that command-ready implies word-ready;
- that a pending word blocks word-ready;
- that the acknowledged flag only rises after `ack_i` and only falls after a write;
- that the done pulse lasts one cycle.

Only the bench scenarios can show that the header length is honoured and clamped, and that the port waits for the acknowledgment after exactly the final word. The same holds for ignored writes leaving everything unchanged, and for a re-enable starting a clean command.

// File: rtl/swcmd_status_port.sv
module swcmd_status_port #(
  parameter int DW        = 32,
  parameter int MAX_EXTRA = 12,
  parameter int LEN_LSB   = 4,
  parameter int LEN_W     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [31:0]   status,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_data,
  input  logic          cmd_ready,
  input  logic          ack_i,
  input  logic          ack_err_i,
  output logic          done_o
);
  localparam int CW = $clog2(MAX_EXTRA + 1);

  logic [CW-1:0]    left_q;
  logic [LEN_W-1:0] len_f;
  logic [CW-1:0]    len_c;
  logic             pend_q, wait_q, ackd_q, err_q, done_q;
  logic             word_rdy, cmd_rdy, take, fwd, ack_ok;

  assign word_rdy = enable && !pend_q && !wait_q;
  assign cmd_rdy  = word_rdy && (left_q == '0);
  assign take     = wr_en && word_rdy;
  assign fwd      = pend_q && cmd_ready;
  assign ack_ok   = ack_i && wait_q && enable;

  assign len_f = wr_data[LEN_LSB +: LEN_W];
  assign len_c = (int'(len_f) > MAX_EXTRA) ? CW'(MAX_EXTRA) : CW'(len_f);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= '0;
      pend_q   <= 1'b0;
      wait_q   <= 1'b0;
      ackd_q   <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      cmd_data <= '0;
    end else if (!enable) begin
      left_q <= '0;
      pend_q <= 1'b0;
      wait_q <= 1'b0;
      ackd_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= ack_ok;
      if (take) begin
        pend_q   <= 1'b1;
        cmd_data <= wr_data;
        ackd_q   <= 1'b0;
        left_q   <= (left_q == '0) ? len_c : left_q - 1'b1;
      end else if (fwd) begin
        pend_q <= 1'b0;
        if (left_q == '0) wait_q <= 1'b1;
      end
      if (ack_ok) begin
        wait_q <= 1'b0;
        ackd_q <= 1'b1;
        err_q  <= ack_err_i;
      end
    end
  end

  assign cmd_valid = pend_q;
  assign done_o    = done_q;
  assign status    = {28'd0, ackd_q, err_q, cmd_rdy, word_rdy};
endmodule

// File: rtl/swcmd_status_port_chk.sv
module swcmd_status_port_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          wr_en,
  input logic [31:0]   status,
  input logic          cmd_valid,
  input logic [DW-1:0] cmd_data,
  input logic          cmd_ready,
  input logic          ack_i,
  input logic          done_o
);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status[31:4] == 28'd0);

  assert_pending_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !status[0]);

  assert_hold_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cmd_valid && !cmd_ready) |=> (!enable || (cmd_valid && $stable(cmd_data))));

  assert_cmd_needs_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> status[0]);

  assert_ack_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> $past(ack_i));

  assert_ack_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[3]) |-> ($past(wr_en) || !$past(enable)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> status[3]);

  assert_off_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (status[1:0] == 2'b00));
endmodule

bind swcmd_status_port swcmd_status_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .status(status),
  .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
  .ack_i(ack_i), .done_o(done_o)
);

// File: tb/swcmd_status_port_bench.sv
module swcmd_status_port_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] status;
  logic        cmd_valid;
  logic [31:0] cmd_data;
  logic        cmd_ready = 1'b1;
  logic        ack_i = 1'b0;
  logic        ack_err_i = 1'b0;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  int n_acc = 0;
  logic [31:0] last_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swcmd_status_port u_swcmd_status_port (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_data(wr_data),
    .status(status), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .ack_i(ack_i), .ack_err_i(ack_err_i), .done_o(done_o)
  );

  always @(posedge clk) if (cmd_valid && cmd_ready) begin
    n_acc++;
    last_word = cmd_data;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_word_rdy();
    while (!status[0]) @(negedge clk);
  endtask

  task automatic send_ack(input logic err);
    @(negedge clk);
    ack_i = 1'b1;
    ack_err_i = err;
    @(negedge clk);
    ack_i = 1'b0;
    ack_err_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset status", status, 32'h0);
    check("R1 reset valid", {31'd0, cmd_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    check("R1 idle status", status, 32'h3);
  endtask

  task automatic t_basic();
    int base;
    base = n_acc;
    cmd_ready = 1'b1;
    write_word(32'h0000_0021);
    check("R2 word-ready low after write", {31'd0, status[0]}, 32'h0);
    check("R3 header forwarded", cmd_data, 32'h21);
    check("R5 cmd-ready low mid command", {31'd0, status[1]}, 32'h0);
    @(negedge clk);
    check("R2 word-ready back after accept", {31'd0, status[0]}, 32'h1);
    check("R5 cmd-ready low before data", {31'd0, status[1]}, 32'h0);
    write_word(32'hAAAA_0001);
    wait_word_rdy();
    write_word(32'hAAAA_0002);
    @(negedge clk);
    check("R4 three words forwarded", n_acc - base, 3);
    check("R6 no word-ready awaiting ack", status[1:0], 2'b00);
    repeat (3) @(negedge clk);
    check("R6 still waiting", status[1:0], 2'b00);
    write_word(32'hDEAD_BEEF);
    @(negedge clk);
    check("R10 ignored write not forwarded", n_acc - base, 3);
    check("R10 ignored write no valid", {31'd0, cmd_valid}, 32'h0);
    check("R10 last word unchanged", last_word, 32'hAAAA_0002);
    send_ack(1'b1);
    check("R7 ack flag set", {31'd0, status[3]}, 32'h1);
    check("R8 error captured", {31'd0, status[2]}, 32'h1);
    check("R9 done pulse", {31'd0, done_o}, 32'h1);
    check("R5 ready after ack", status[1:0], 2'b11);
    @(negedge clk);
    check("R9 done one cycle", {31'd0, done_o}, 32'h0);
  endtask

  task automatic t_hold();
    cmd_ready = 1'b0;
    write_word(32'h0000_0003);
    check("R7 ack cleared by write", {31'd0, status[3]}, 32'h0);
    repeat (3) @(negedge clk);
    check("R3 valid held", {31'd0, cmd_valid}, 32'h1);
    check("R3 data held", cmd_data, 32'h3);
    check("R2 word-ready low while held", {31'd0, status[0]}, 32'h0);
    cmd_ready = 1'b1;
    @(negedge clk);
    check("R3 valid drops after accept", {31'd0, cmd_valid}, 32'h0);
    check("R4 zero-length waits for ack", status[1:0], 2'b00);
    send_ack(1'b0);
    check("R8 success captured", {31'd0, status[2]}, 32'h0);
    check("R7 ack set", {31'd0, status[3]}, 32'h1);
  endtask

  task automatic t_clamp();
    int base;
    base = n_acc;
    cmd_ready = 1'b1;
    write_word(32'h0000_00F5);
    for (int i = 0; i < 11; i++) begin
      wait_word_rdy();
      write_word(32'h100 + i);
    end
    @(negedge clk);
    check("R4 still open before 12th word", status[1:0], 2'b01);
    write_word(32'h1FF);
    @(negedge clk);
    check("R4 clamped to 13 words", n_acc - base, 13);
    check("R4 waits after 12 extra words", status[1:0], 2'b00);
    send_ack(1'b1);
    check("R8 error after clamp", status[3:0], 4'hF);
  endtask

  task automatic t_disable();
    cmd_ready = 1'b1;
    write_word(32'h0000_0031);
    wait_word_rdy();
    write_word(32'h55);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R11 disabled status zero", status, 32'h0);
    enable = 1'b1;
    @(negedge clk);
    check("R11 fresh after enable", status, 32'h3);
    write_word(32'h0000_0001);
    @(negedge clk);
    check("R11 new header single word waits ack", status[1:0], 2'b00);
    send_ack(1'b0);
    check("R11 clean command acked", status[3:0], 4'hB);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_hold();
    t_clamp();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule